// File: doc/BRIEF.md
# Per-Task Availability Region Tracker

This block sits beside a small microcontroller core and decides which real-time tasks may keep running. On every cycle it compares the core's program counter with a table of per-task code windows, each given by an inclusive lower and upper address. The result is the index of the task that is running now. It also holds a bitmask, one bit per task, of the tasks that are still allowed to execute. The scheduler reads this mask and skips any task whose bit is clear.

An external integrity checker pulses a violation input when it catches the running task misbehaving. The tracker then clears that task's bit and raises a single-cycle non-maskable interrupt request. The request steers the core into an OS routine that kills the task and yields to another one. Only that one task loses its right to run.

The task stays barred until a trusted update routine has run to its exit point. The exit point is recognised when the program counter reaches a configured exit address during a cycle with no data access. The bit then returns, and the other tasks keep running throughout.

The window table and the exit address are written while a configuration enable is high. The first falling edge of that enable locks them until the next reset.

Top module: `task_avail_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, the availability mask is all ones and the interrupt request is low.
- R2: The running-task index is the task whose window satisfies lower <= pc <= upper (bounds inclusive), shown combinationally with run_valid high; if windows overlap, the lowest index wins.
- R3: When pc lies outside every window, run_valid is 0 and the running-task index reads 0.
- R4: In the idle-execution state, a violation pulse sampled while a task is running clears that task's mask bit at that clock edge. nmi_req is high for exactly the one following cycle.
- R5: A violation pulse sampled while no task is running leaves the mask unchanged and raises no interrupt request.
- R6: From the accepted violation until the block is back in the idle-execution state, further violation pulses are ignored: the mask does not change and no interrupt request is raised.
- R7: After a revocation, the clock edge that sees pc equal to the exit address with mem_wen and mem_ren both low starts reinstatement. The revoked bit returns at the following edge, so it reads back two edges after the exit is sampled. An exit address seen during a data access does not count.
- R8: Window and exit writes (cfg_wr, cfg_exit_wr) take effect only while cfg_en is high and before the first falling edge of cfg_en after reset; after that edge the table is locked until reset.
- R9: An entry that was never written has lower = all ones and upper = 0, so it matches no address.
- R10: A revocation clears only the offending task's bit; every other bit of the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration window; its falling edge locks the table |
| cfg_wr | input | 1 | Write strobe for one task's window |
| cfg_idx | input | IDX_W (3) | Task entry selected by cfg_wr |
| cfg_lo | input | ADDR_W (16) | Inclusive lower code address |
| cfg_hi | input | ADDR_W (16) | Inclusive upper code address |
| cfg_exit_wr | input | 1 | Write strobe for the update-routine exit address |
| cfg_exit | input | ADDR_W (16) | Update-routine exit address |
| pc | input | ADDR_W (16) | Core program counter |
| mem_wen | input | 1 | Core data-write enable |
| mem_ren | input | 1 | Core data-read enable |
| viol_in | input | 1 | Integrity-violation pulse from the external checker |
| avail_mask | output | NUM_TASKS (8) | Tasks still allowed to run |
| run_idx | output | IDX_W (3) | Index of the running task |
| run_valid | output | 1 | pc lies in some task window |
| nmi_req | output | 1 | Single-cycle non-maskable interrupt request |

## Verification
The hardest case to reach from the ports is a violation pulse that arrives while a revocation is still pending. To build it, the stimulus first has a task revoked. It then moves pc into a second task's window and pulses the violation input again, before pc has reached the exit address. The stimulus also holds pc on the exit address with a data read active, which checks that the flag qualification blocks reinstatement. Only after that does it drop the flag and count the two edges until the revoked bit returns.

// File: rtl/tat_pkg.sv
package tat_pkg;
  typedef enum logic [1:0] {
    ST_EXEC   = 2'd0,
    ST_REVOKE = 2'd1,
    ST_REINST = 2'd2
  } tat_state_e;
endpackage

// File: rtl/tat_bound_regs.sv
module tat_bound_regs #(
  parameter int NUM_TASKS = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_en,
  input  logic                        cfg_wr,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [ADDR_W-1:0]           cfg_lo,
  input  logic [ADDR_W-1:0]           cfg_hi,
  input  logic                        cfg_exit_wr,
  input  logic [ADDR_W-1:0]           cfg_exit,
  output logic [NUM_TASKS*ADDR_W-1:0] lo_flat,
  output logic [NUM_TASKS*ADDR_W-1:0] hi_flat,
  output logic [ADDR_W-1:0]           exit_addr,
  output logic                        locked
);
  logic cfg_en_q;
  logic locked_d;
  logic wr_ok;
  logic exit_en;

  // The table locks on the first falling edge of the configuration enable.
  assign locked_d = locked | (cfg_en_q & ~cfg_en);
  assign wr_ok    = cfg_en & ~locked;
  assign exit_en  = wr_ok & cfg_exit_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q <= 1'b0;
      locked   <= 1'b0;
    end else begin
      cfg_en_q <= cfg_en;
      locked   <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_addr <= '1;
    end else if (exit_en) begin
      exit_addr <= cfg_exit;
    end
  end

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_ok & cfg_wr & (cfg_idx == IDX_W'(i));

    // An unwritten entry has lower > upper, so it never matches.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_flat[i*ADDR_W +: ADDR_W] <= '1;
        hi_flat[i*ADDR_W +: ADDR_W] <= '0;
      end else if (ent_en) begin
        lo_flat[i*ADDR_W +: ADDR_W] <= cfg_lo;
        hi_flat[i*ADDR_W +: ADDR_W] <= cfg_hi;
      end
    end
  end
endmodule

// File: rtl/tat_task_decode.sv
module tat_task_decode #(
  parameter int NUM_TASKS = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic [ADDR_W-1:0]           pc,
  input  logic [NUM_TASKS*ADDR_W-1:0] lo_flat,
  input  logic [NUM_TASKS*ADDR_W-1:0] hi_flat,
  output logic                        run_valid,
  output logic [IDX_W-1:0]            run_idx
);
  logic [NUM_TASKS-1:0] hit;

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_cmp
    assign hit[i] = (pc >= lo_flat[i*ADDR_W +: ADDR_W]) &&
                    (pc <= hi_flat[i*ADDR_W +: ADDR_W]);
  end

  // Scanning from the top down lets the lowest index win.
  always_comb begin
    run_valid = 1'b0;
    run_idx   = '0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        run_valid = 1'b1;
        run_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tat_avail_ctrl.sv
module tat_avail_ctrl
  import tat_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 viol_in,
  input  logic                 run_valid,
  input  logic [IDX_W-1:0]     run_idx,
  input  logic [ADDR_W-1:0]    pc,
  input  logic                 mem_wen,
  input  logic                 mem_ren,
  input  logic [ADDR_W-1:0]    exit_addr,
  output logic [NUM_TASKS-1:0] avail_mask,
  output logic                 nmi_req,
  output tat_state_e           state
);
  tat_state_e           state_d;
  logic [NUM_TASKS-1:0] mask_d;
  logic [IDX_W-1:0]     pend_q;
  logic [IDX_W-1:0]     pend_d;
  logic                 nmi_d;
  logic                 take_viol;
  logic                 exit_hit;
  logic                 mask_en;
  logic                 pend_en;

  // A stalled data access holds pc, so the exit counts only on a non-data cycle.
  assign exit_hit  = (pc == exit_addr) & ~mem_wen & ~mem_ren;
  assign take_viol = (state == ST_EXEC) & viol_in & run_valid;

  always_comb begin
    state_d = state;
    mask_d  = avail_mask;
    pend_d  = pend_q;
    nmi_d   = 1'b0;
    mask_en = 1'b0;
    pend_en = 1'b0;
    case (state)
      ST_EXEC: begin
        if (take_viol) begin
          mask_d  = avail_mask & ~(NUM_TASKS'(1) << run_idx);
          mask_en = 1'b1;
          pend_d  = run_idx;
          pend_en = 1'b1;
          nmi_d   = 1'b1;
          state_d = ST_REVOKE;
        end
      end
      ST_REVOKE: begin
        if (exit_hit) begin
          state_d = ST_REINST;
        end
      end
      ST_REINST: begin
        mask_d  = avail_mask | (NUM_TASKS'(1) << pend_q);
        mask_en = 1'b1;
        state_d = ST_EXEC;
      end
      default: begin
        state_d = ST_EXEC;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_EXEC;
      nmi_req <= 1'b0;
    end else begin
      state   <= state_d;
      nmi_req <= nmi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_mask <= '1;
    end else if (mask_en) begin
      avail_mask <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/task_avail_tracker.sv
module task_avail_tracker
  import tat_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_wr,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_lo,
  input  logic [ADDR_W-1:0]    cfg_hi,
  input  logic                 cfg_exit_wr,
  input  logic [ADDR_W-1:0]    cfg_exit,
  input  logic [ADDR_W-1:0]    pc,
  input  logic                 mem_wen,
  input  logic                 mem_ren,
  input  logic                 viol_in,
  output logic [NUM_TASKS-1:0] avail_mask,
  output logic [IDX_W-1:0]     run_idx,
  output logic                 run_valid,
  output logic                 nmi_req
);
  logic [NUM_TASKS*ADDR_W-1:0] lo_flat;
  logic [NUM_TASKS*ADDR_W-1:0] hi_flat;
  logic [ADDR_W-1:0]           exit_addr;
  logic                        locked;
  tat_state_e                  state;

  tat_bound_regs #(.NUM_TASKS(NUM_TASKS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_wr     (cfg_wr),
    .cfg_idx    (cfg_idx),
    .cfg_lo     (cfg_lo),
    .cfg_hi     (cfg_hi),
    .cfg_exit_wr(cfg_exit_wr),
    .cfg_exit   (cfg_exit),
    .lo_flat    (lo_flat),
    .hi_flat    (hi_flat),
    .exit_addr  (exit_addr),
    .locked     (locked)
  );

  tat_task_decode #(.NUM_TASKS(NUM_TASKS), .ADDR_W(ADDR_W)) u_dec (
    .pc       (pc),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat),
    .run_valid(run_valid),
    .run_idx  (run_idx)
  );

  tat_avail_ctrl #(.NUM_TASKS(NUM_TASKS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .viol_in   (viol_in),
    .run_valid (run_valid),
    .run_idx   (run_idx),
    .pc        (pc),
    .mem_wen   (mem_wen),
    .mem_ren   (mem_ren),
    .exit_addr (exit_addr),
    .avail_mask(avail_mask),
    .nmi_req   (nmi_req),
    .state     (state)
  );
endmodule

// File: rtl/task_avail_tracker_chk.sv
module task_avail_tracker_chk
  import tat_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int ADDR_W    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        viol_in,
  input logic                        run_valid,
  input logic                        nmi_req,
  input logic [NUM_TASKS-1:0]        avail_mask,
  input tat_state_e                  state,
  input logic                        locked,
  input logic [NUM_TASKS*ADDR_W-1:0] lo_flat,
  input logic [NUM_TASKS*ADDR_W-1:0] hi_flat
);
  // R4
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R10
  revoke_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> ($countones($past(avail_mask) & ~avail_mask) <= 1));

  // R10
  drop_needs_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(avail_mask) & ~avail_mask)) |-> nmi_req);

  // R5
  no_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_in && !run_valid && state == ST_EXEC) |=> (!nmi_req && $stable(avail_mask)));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_in && state != ST_EXEC) |=> !nmi_req);

  // R7
  restore_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(avail_mask & ~$past(avail_mask))) |-> ($past(state) == ST_REINST));

  // R8
  table_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(lo_flat) && $stable(hi_flat)));
endmodule

bind task_avail_tracker task_avail_tracker_chk #(.NUM_TASKS(NUM_TASKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .viol_in   (viol_in),
  .run_valid (run_valid),
  .nmi_req   (nmi_req),
  .avail_mask(avail_mask),
  .state     (state),
  .locked    (locked),
  .lo_flat   (lo_flat),
  .hi_flat   (hi_flat)
);

// File: tb/task_avail_tracker_test.sv
module task_avail_tracker_test;
  localparam int NT = 8;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_wr;
  logic [IW-1:0] cfg_idx;
  logic [AW-1:0] cfg_lo;
  logic [AW-1:0] cfg_hi;
  logic          cfg_exit_wr;
  logic [AW-1:0] cfg_exit;
  logic [AW-1:0] pc;
  logic          mem_wen;
  logic          mem_ren;
  logic          viol_in;
  logic [NT-1:0] avail_mask;
  logic [IW-1:0] run_idx;
  logic          run_valid;
  logic          nmi_req;

  int checks   = 0;
  int failures = 0;

  task_avail_tracker #(.NUM_TASKS(NT), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_exit_wr(cfg_exit_wr), .cfg_exit(cfg_exit),
    .pc(pc), .mem_wen(mem_wen), .mem_ren(mem_ren), .viol_in(viol_in),
    .avail_mask(avail_mask), .run_idx(run_idx), .run_valid(run_valid), .nmi_req(nmi_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Decode vectors: {pc, expected run_valid, expected run_idx}.
  // Tasks 0..6 occupy 0x1000*(k+1) .. +0xFF; task 7 is never written.
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {16'h1000, 1'b1, 3'd0},
    {16'h10FF, 1'b1, 3'd0},
    {16'h1100, 1'b0, 3'd0},
    {16'h0FFF, 1'b0, 3'd0},
    {16'h2080, 1'b1, 3'd1},
    {16'h3050, 1'b1, 3'd2},
    {16'h7000, 1'b1, 3'd6},
    {16'h70FF, 1'b1, 3'd6},
    {16'h8000, 1'b0, 3'd0},
    {16'hFFFF, 1'b0, 3'd0},
    {16'hF000, 1'b0, 3'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_lo = '0; cfg_hi = '0;
    cfg_exit_wr = 1'b0; cfg_exit = '0; pc = 16'h0000; mem_wen = 1'b0; mem_ren = 1'b0;
    viol_in = 1'b0;
    #35;
    chk("R1 mask in reset", 32'(avail_mask), 32'hFF);
    chk("R1 nmi in reset", 32'(nmi_req), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 mask after release", 32'(avail_mask), 32'hFF);
    chk("R1 nmi after release", 32'(nmi_req), 32'h0);
    pc = 16'h1000;
    #1;
    chk("R9 unwritten table matches nothing", 32'(run_valid), 32'h0);

    // Configuration
    cfg_en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      cfg_wr = 1'b1; cfg_idx = IW'(k);
      cfg_lo = 16'(16'h1000 * (k + 1)); cfg_hi = 16'(16'h1000 * (k + 1) + 16'h00FF);
      tick();
    end
    cfg_wr = 1'b0;
    cfg_exit_wr = 1'b1; cfg_exit = 16'hF000;
    tick();
    cfg_exit_wr = 1'b0;
    cfg_en = 1'b0;
    tick();

    // Locked: write task 7 must be ignored
    cfg_en = 1'b1; cfg_wr = 1'b1; cfg_idx = 3'd7; cfg_lo = 16'h8000; cfg_hi = 16'h80FF;
    tick();
    cfg_en = 1'b0; cfg_wr = 1'b0;
    tick();

    // Vector walk: R2, R3, R8, R9
    for (int k = 0; k < NV; k++) begin
      pc = VEC[k][19:4];
      tick();
      chk("R2/R3 run_valid", 32'(run_valid), 32'(VEC[k][3]));
      chk("R2/R3 run_idx", 32'(run_idx), 32'(VEC[k][2:0]));
    end

    // R4: revoke task 2
    pc = 16'h3050; viol_in = 1'b1;
    tick();
    viol_in = 1'b0;
    chk("R4 mask cleared", 32'(avail_mask), 32'hFB);
    chk("R4 nmi pulse", 32'(nmi_req), 32'h1);
    tick();
    chk("R4 nmi one cycle", 32'(nmi_req), 32'h0);

    // R6: violation while revocation pending
    pc = 16'h5000; viol_in = 1'b1;
    tick();
    viol_in = 1'b0;
    chk("R6 mask unchanged", 32'(avail_mask), 32'hFB);
    chk("R6 no nmi", 32'(nmi_req), 32'h0);

    // R7: exit during data read does not count
    pc = 16'hF000; mem_ren = 1'b1;
    tick();
    tick();
    chk("R7 exit blocked by read", 32'(avail_mask), 32'hFB);
    mem_ren = 1'b0;
    tick();
    chk("R7 one edge after exit", 32'(avail_mask), 32'hFB);
    pc = 16'h0100;
    tick();
    chk("R7 bit restored", 32'(avail_mask), 32'hFF);

    // R5: violation with no task
    pc = 16'h0500; viol_in = 1'b1;
    tick();
    viol_in = 1'b0;
    chk("R5 mask unchanged", 32'(avail_mask), 32'hFF);
    chk("R5 no nmi", 32'(nmi_req), 32'h0);

    // R10: revoke task 5, only its bit drops
    pc = 16'h6010; viol_in = 1'b1;
    tick();
    viol_in = 1'b0;
    chk("R10 only bit 5 cleared", 32'(avail_mask), 32'hDF);
    pc = 16'hF000;
    tick();
    tick();
    chk("R7 task 5 restored", 32'(avail_mask), 32'hFF);

    // R1: reset mid-revocation restores the full mask
    pc = 16'h1010; viol_in = 1'b1;
    tick();
    viol_in = 1'b0;
    chk("R4 task 0 cleared", 32'(avail_mask), 32'hFE);
    rst_n = 1'b0;
    #1;
    chk("R1 reset restores mask", 32'(avail_mask), 32'hFF);
    tick();
    rst_n = 1'b1;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule